// File: doc/BRIEF.md
# Return-Address Stack

This block keeps the return addresses of a small processor core in a dedicated last-in first-out store of six 12-bit levels that lives outside the data address space. It has no pointer: every level is a register, and the whole column shifts by one place on each accepted operation. A subroutine call or an accepted interrupt pushes the current program counter into the shallowest level while every stored address moves one level deeper. A return moves the shallowest level out to the program counter while every other level moves one place shallower.

The stack never signals an error. When a seventh address is pushed the deepest entry falls off the end and the occupancy stays at six. When a return is attempted with nothing stored the occupancy stays at zero and no address is offered, so the core simply continues with its next sequential instruction. The popped address and its valid flag are combinational from the current state and the request, so the core can load its program counter in the same cycle as the return.

Top module: `ras_stack`

## Requirements
- R1: After reset the occupancy is 0, `ret_valid_o` is 0 and `ret_addr_o` is 0.
- R2: A push (`push_i`=1) places `pc_i` in the shallowest level at the next clock edge, moves every stored level one place deeper and raises the occupancy by one.
- R3: A pop (`pop_i`=1, `push_i`=0) with occupancy above 0 raises `ret_valid_o` in the same cycle with `ret_addr_o` equal to the most recently pushed address still stored; at the next edge the levels move one place shallower and the occupancy falls by one.
- R4: The occupancy never exceeds 6; a push at occupancy 6 keeps it at 6 and discards the oldest address, so later pops return the six newest addresses in reverse push order.
- R5: A pop at occupancy 0 leaves `ret_valid_o` at 0 and the occupancy at 0.
- R6: When `push_i` and `pop_i` are both 1 the pop is rejected (`ret_valid_o`=0) and the push is performed as in R2 and R4.
- R7: A pop fills the vacated deepest level with zero, so `ret_addr_o` reads 0 whenever the occupancy has returned to 0.
- R8: Every 12-bit value from 0x000 to 0xFFF is stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Call or accepted interrupt: store `pc_i` |
| pop_i | input | 1 | Return request |
| pc_i | input | 12 | Program counter value to store |
| ret_addr_o | output | 12 | Shallowest stored address |
| ret_valid_o | output | 1 | Pop accepted this cycle; load `ret_addr_o` into the program counter |
| level_o | output | 3 | Number of stored addresses, 0 to 6 |

## Verification
Push and pop can both be requested in one cycle, and this collision is the case the bench drives deliberately: a pseudo-random walk raises both strobes together at empty, partly filled and full occupancy. The bench judges each such cycle against its own queue model, expecting no valid return, the pushed address at the top afterwards and the occupancy raised or held at six. The same walk also stacks pushes on a full stack and pops on an empty one, and every cycle compares the offered address and the occupancy with the model.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Occupancy after one cycle, given the accepted operations.
  function automatic int unsigned ras_next_level(int unsigned cur, bit do_push,
                                                 bit do_pop, int unsigned depth);
    int unsigned nxt;
    nxt = cur;
    if (do_push) begin
      if (cur < depth) nxt = cur + 1;
    end else if (do_pop) begin
      if (cur > 0) nxt = cur - 1;
    end
    return nxt;
  endfunction

  // A pop is accepted only when alone and the stack holds something.
  function automatic bit ras_pop_accept(bit push, bit pop, bit empty);
    return pop && !push && !empty;
  endfunction

endpackage

// File: rtl/ras_level_cell.sv
module ras_level_cell #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_down,
  input  logic          shift_up,
  input  logic [AW-1:0] from_shallower,
  input  logic [AW-1:0] from_deeper,
  output logic [AW-1:0] value_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          value_o <= '0;
    else if (shift_down) value_o <= from_shallower;
    else if (shift_up)   value_o <= from_deeper;
  end

endmodule

// File: rtl/ras_occupancy.sv
module ras_occupancy
  import ras_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_push,
  input  logic          do_pop,
  output logic [CW-1:0] level_o,
  output logic          empty_o
);

  logic [CW-1:0] level_nxt;

  always_comb
    level_nxt = CW'(ras_next_level(int'(level_o), do_push, do_pop, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_o <= '0;
    else        level_o <= level_nxt;
  end

  assign empty_o = (level_o == '0);

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_o) <= DEPTH);

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && int'(level_o) == DEPTH) |=> int'(level_o) == DEPTH);

  assert_empty_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_push && empty_o) |=> empty_o);

endmodule

// File: rtl/ras_stack.sv
module ras_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int AW    = 12,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] ret_addr_o,
  output logic          ret_valid_o,
  output logic [CW-1:0] level_o
);

  logic [AW-1:0] lvl [DEPTH];
  logic          empty;
  logic          do_push;
  logic          do_pop;
  logic          collide;

  assign do_push = push_i;
  assign do_pop  = ras_pop_accept(push_i, pop_i, empty);
  assign collide = push_i && pop_i;

  for (genvar k = 0; k < DEPTH; k++) begin : g_level
    logic [AW-1:0] above;
    logic [AW-1:0] below;
    if (k == 0) begin : g_top
      assign above = pc_i;
    end else begin : g_mid
      assign above = lvl[k-1];
    end
    if (k == DEPTH - 1) begin : g_bottom
      assign below = '0;
    end else begin : g_inner
      assign below = lvl[k+1];
    end
    ras_level_cell #(.AW(AW)) u_cell (
      .clk            (clk),
      .rst_n          (rst_n),
      .shift_down     (do_push),
      .shift_up       (do_pop),
      .from_shallower (above),
      .from_deeper    (below),
      .value_o        (lvl[k])
    );
  end

  ras_occupancy #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_push (do_push),
    .do_pop  (do_pop),
    .level_o (level_o),
    .empty_o (empty)
  );

  assign ret_addr_o  = lvl[0];
  assign ret_valid_o = do_pop;

  assert_push_lands_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> ret_addr_o == $past(pc_i));

  assert_pop_moves_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid_o |=> ret_addr_o == $past(lvl[1]));

  assert_pop_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid_o |=> level_o == $past(level_o) - 1'b1);

  assert_no_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == '0) |-> !ret_valid_o);

  assert_collision_push_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> (ret_addr_o == $past(pc_i)) && (level_o != '0));

  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid_o |=> lvl[DEPTH-1] == '0);

  assert_empty_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == '0) |-> ret_addr_o == '0);

endmodule

// File: tb/tb_ras_stack.sv
module tb_ras_stack;
  localparam int DEPTH = 6;
  localparam int AW    = 12;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic [AW-1:0] ret_addr_o;
  logic          ret_valid_o;
  logic [CW-1:0] level_o;

  int checks = 0;
  int errors = 0;
  int model[$];

  always #4 clk = ~clk;

  ras_stack #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
    .ret_addr_o(ret_addr_o), .ret_valid_o(ret_valid_o), .level_o(level_o)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  // One cycle: drive after falling edge, check combinational outputs,
  // clock, then check the registered state against the model.
  task automatic step(bit p, bit q, int pc, string req);
    bit exp_valid;
    int exp_addr;
    @(negedge clk);
    push_i = p; pop_i = q; pc_i = AW'(pc);
    #1;
    exp_valid = q && !p && model.size() > 0;
    exp_addr  = (model.size() > 0) ? model[0] : 0;
    check({req, " valid"}, int'(ret_valid_o), int'(exp_valid));
    check({req, " addr"}, int'(ret_addr_o), exp_addr);
    @(posedge clk);
    if (p) begin
      model.push_front(pc & 12'hFFF);
      if (model.size() > DEPTH) void'(model.pop_back());
    end else if (q && model.size() > 0) begin
      void'(model.pop_front());
    end
    #1;
    check({req, " level"}, int'(level_o), model.size());
    check({req, " top"}, int'(ret_addr_o), (model.size() > 0) ? model[0] : 0);
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lfsr;
    #10;
    check("R1 level", int'(level_o), 0);
    check("R1 valid", int'(ret_valid_o), 0);
    check("R1 addr", int'(ret_addr_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: pop on empty stack
    step(0, 1, 0, "R5");
    // R2/R4 sweep: push n addresses (n up to 9), then pop 9 times (R3, R5, R7)
    for (int n = 0; n <= 9; n++) begin
      for (int i = 0; i < n; i++) step(1, 0, (n * 16 + i) * 37 + 5, "R2/R4");
      for (int i = 0; i < 9; i++) step(0, 1, 0, "R3/R7");
      check("R7 empty reads zero", int'(ret_addr_o), 0);
    end
    // R8: extreme values
    step(1, 0, 12'hFFF, "R8");
    step(1, 0, 12'h000, "R8");
    step(1, 0, 12'hAAA, "R8");
    step(1, 0, 12'h555, "R8");
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R8");
    // R6: collision at empty, partial and full occupancy
    step(1, 1, 12'h123, "R6 empty");
    step(1, 1, 12'h456, "R6 partial");
    for (int i = 0; i < 5; i++) step(1, 0, 12'h700 + i, "R4");
    step(1, 1, 12'hABC, "R6 full");
    for (int i = 0; i < 7; i++) step(0, 1, 0, "R3");
    // Pseudo-random walk covering all operation mixes
    lfsr = 32'h1ACE;
    for (int i = 0; i < 3000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step(lfsr[0], lfsr[1] | lfsr[2], (lfsr >> 3) & 12'hFFF, "R2/R3/R6 walk");
    end
    @(negedge clk);
    push_i = 0; pop_i = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule